// File: doc/BRIEF.md
# Synchronous Serial-Clock Engine

This block adds a synchronous serial clock to an asynchronous character engine. It produces the sample and shift strobes that drive the receive and transmit shift registers. In master mode it makes the serial clock itself. The clock changes level once for each baud tick from an outside baud generator. The block also drives the clock pad output-enable in this mode. In master mode the clock can run all the time, or it can stop while the character engine reports no frame in flight. This covers both idle and break.

In slave mode the external serial clock enters as an ordinary data input. It passes through a synchronizer that is one or two stages deep, chosen by configuration, and then through an edge detector. Every flop runs on the system clock. Configuration picks the edge on which received data is sampled. Transmit data shifts on the opposite edge, so it is stable at the moment it is sampled. A framing mode without start or stop bits always samples on the falling edge.

Top module: `sclk_engine`

## Requirements
- R1: During reset and directly after it, `sclk_out` is 1 and both `sample_stb` and `shift_stb` are 0.
- R2: `sclk_oe` is 1 when `cfg_master` is 1 (master) and 0 when `cfg_master` is 0 (slave).
- R3: In master mode, a `baud_tick` that is high in a system-clock cycle makes `sclk_out` invert on the next rising system-clock edge. The strobe for that serial edge is high during the cycle that follows that edge, and only then. `sclk_out` does not change in any cycle without a tick.
- R4: In master mode with `cfg_gate_idle`=1 and `frame_busy`=0, a low clock still completes its period and goes back to 1. After that, ticks leave it at 1 and make no strobes. With `cfg_gate_idle`=0 the clock keeps toggling on ticks whatever `frame_busy` is.
- R5: In slave mode with `cfg_two_stage`=0, a change of `sclk_in` first sampled at system-clock edge E gives its strobe during the cycle between E and E+1.
- R6: In slave mode with `cfg_two_stage`=1, the same change gives its strobe one cycle later, between E+1 and E+2, and no strobe between E and E+1.
- R7: With `cfg_no_frame`=0, the setting of `cfg_fall_edge` decides which serial edge samples and which shifts. With `cfg_fall_edge`=0, a rising serial edge produces `sample_stb` and a falling edge produces `shift_stb`. With `cfg_fall_edge`=1 the two are swapped.
- R8: With `cfg_no_frame`=1, sampling takes place on falling serial edges and shifting on rising ones, whatever `cfg_fall_edge` is.
- R9: Each serial edge produces exactly one one-cycle strobe. `sample_stb` and `shift_stb` are never high in the same cycle.
- R10: In slave mode, `baud_tick` has no effect: `sclk_out` stays 1 and no strobe appears. In master mode, `sclk_in` has no effect: without ticks, no strobe appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master (generate the clock), 0 = slave |
| cfg_two_stage | input | 1 | 1 = two-stage synchronizer on `sclk_in`, 0 = one stage |
| cfg_fall_edge | input | 1 | 1 = sample on the falling edge, 0 = on the rising edge |
| cfg_gate_idle | input | 1 | 1 = stop the master clock while no frame is in flight |
| cfg_no_frame | input | 1 | 1 = framing without start or stop bits; forces falling-edge sampling |
| baud_tick | input | 1 | Half-period strobe from the baud generator |
| frame_busy | input | 1 | Character engine has a frame in flight (not idle, not break) |
| sclk_in | input | 1 | External serial clock pin |
| sclk_out | output | 1 | Generated serial clock; idles high |
| sclk_oe | output | 1 | Output-enable for the clock pad |
| sample_stb | output | 1 | One-cycle strobe to shift received data in |
| shift_stb | output | 1 | One-cycle strobe to advance transmit data |

## Verification
The strobe logic can meet a sample edge and a shift edge close together, and the edge-select logic must never turn both into strobes in the same cycle. The bench sends rising and falling slave edges through every combination of `cfg_fall_edge` and `cfg_no_frame`. It then checks the cycle after each edge for the one expected strobe, and the cycle after that for quiet. Gating can also coincide with a tick. The bench drops `frame_busy` while the master clock is low and checks that the next tick still completes the period before the clock parks high.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic {
    EDGE_RISE = 1'b0,
    EDGE_FALL = 1'b1
  } sclk_edge_e;

  function automatic sclk_edge_e sample_edge(input logic fall_cfg, input logic no_frame);
    return (fall_cfg || no_frame) ? EDGE_FALL : EDGE_RISE;
  endfunction
endpackage

// File: rtl/sclk_rst_sync.sv
module sclk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/sclk_in_sync.sv
module sclk_in_sync #(
  parameter int LONG_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic two_i,
  input  logic sclk_i,
  output logic rise_o,
  output logic fall_o
);
  logic [LONG_STAGES-1:0] stg_q;
  logic                   sel;
  logic                   prev_q;

  genvar g;
  generate
    for (g = 0; g < LONG_STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = sclk_i;
      end else begin : g_next
        assign d = stg_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= 1'b1;
        else         stg_q[g] <= d;
      end
    end
  endgenerate

  always_comb begin
    sel = two_i ? stg_q[LONG_STAGES-1] : stg_q[0];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sel;
  end

  assign rise_o = sel & ~prev_q;
  assign fall_o = ~sel & prev_q;

  // R5: one-stage path turns a 0->1 pin change into a rise one cycle after capture
  a_r5_one_stage_latency: assert property (@(posedge clk) disable iff (!rst_ni)
    (rise_o && !two_i && !$past(two_i)) |-> ($past(sclk_i) && !$past(sclk_i, 2)));
endmodule

// File: rtl/sclk_master_gen.sv
module sclk_master_gen (
  input  logic clk,
  input  logic rst_ni,
  input  logic master_i,
  input  logic gate_i,
  input  logic busy_i,
  input  logic tick_i,
  output logic sclk_o,
  output logic rise_o,
  output logic fall_o
);
  logic lvl_q, lvl_d;
  logic rise_q, rise_d;
  logic fall_q, fall_d;
  logic run;
  logic adv;

  always_comb begin
    run    = ~gate_i | busy_i;
    adv    = master_i & tick_i & (run | ~lvl_q);
    lvl_d  = lvl_q;
    rise_d = 1'b0;
    fall_d = 1'b0;
    if (!master_i) begin
      lvl_d = 1'b1;
    end else if (adv) begin
      lvl_d  = ~lvl_q;
      rise_d = ~lvl_q;
      fall_d = lvl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b1;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      lvl_q  <= lvl_d;
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end

  assign sclk_o = lvl_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R3: no tick, no clock movement while mastering
  a_r3_tick_only: assert property (@(posedge clk) disable iff (!rst_ni)
    (master_i && !tick_i) |=> $stable(sclk_o));
  // R4: parked high clock stays parked while gated
  a_r4_gated_parked: assert property (@(posedge clk) disable iff (!rst_ni)
    (master_i && gate_i && !busy_i && sclk_o) |=> (sclk_o && !rise_o && !fall_o));
endmodule

// File: rtl/sclk_engine.sv
module sclk_engine #(
  parameter int SYNC_LONG  = 2,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic cfg_two_stage,
  input  logic cfg_fall_edge,
  input  logic cfg_gate_idle,
  input  logic cfg_no_frame,
  input  logic baud_tick,
  input  logic frame_busy,
  input  logic sclk_in,
  output logic sclk_out,
  output logic sclk_oe,
  output logic sample_stb,
  output logic shift_stb
);
  import sclk_pkg::*;

  logic       rst_int_n;
  logic       s_rise, s_fall;
  logic       m_rise, m_fall;
  logic       e_rise, e_fall;
  sclk_edge_e smp_edge;

  sclk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_int_n)
  );

  sclk_in_sync #(.LONG_STAGES(SYNC_LONG)) u_sync (
    .clk    (clk),
    .rst_ni (rst_int_n),
    .two_i  (cfg_two_stage),
    .sclk_i (sclk_in),
    .rise_o (s_rise),
    .fall_o (s_fall)
  );

  sclk_master_gen u_mgen (
    .clk      (clk),
    .rst_ni   (rst_int_n),
    .master_i (cfg_master),
    .gate_i   (cfg_gate_idle),
    .busy_i   (frame_busy),
    .tick_i   (baud_tick),
    .sclk_o   (sclk_out),
    .rise_o   (m_rise),
    .fall_o   (m_fall)
  );

  always_comb begin
    e_rise   = cfg_master ? m_rise : s_rise;
    e_fall   = cfg_master ? m_fall : s_fall;
    smp_edge = sample_edge(cfg_fall_edge, cfg_no_frame);
    if (smp_edge == EDGE_FALL) begin
      sample_stb = e_fall;
      shift_stb  = e_rise;
    end else begin
      sample_stb = e_rise;
      shift_stb  = e_fall;
    end
  end

  assign sclk_oe = cfg_master;

  // R9: strobes exclusive
  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(sample_stb && shift_stb));
  // R8: start/stop-less framing samples only on falling serial edges
  a_r8_no_frame_falling: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cfg_no_frame && sample_stb) |-> e_fall);
  // R1: nothing strobes while the internal reset is held
  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_int_n |-> (!sample_stb && !shift_stb));
endmodule

// File: tb/sclk_engine_test.sv
`timescale 1ns/1ps
module sclk_engine_test;
  logic clk, rst_n;
  logic cfg_master, cfg_two_stage, cfg_fall_edge, cfg_gate_idle, cfg_no_frame;
  logic baud_tick, frame_busy, sclk_in;
  logic sclk_out, sclk_oe, sample_stb, shift_stb;
  int total = 0;
  int bad = 0;
  bit done = 0;

  // {fall_edge, no_frame, edge_is_rise, exp_sample, exp_shift}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00110, 5'b00001, 5'b10101, 5'b10010,
    5'b01101, 5'b01010, 5'b11101, 5'b11010
  };

  sclk_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_two_stage(cfg_two_stage),
    .cfg_fall_edge(cfg_fall_edge), .cfg_gate_idle(cfg_gate_idle), .cfg_no_frame(cfg_no_frame),
    .baud_tick(baud_tick), .frame_busy(frame_busy), .sclk_in(sclk_in),
    .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sample_stb(sample_stb), .shift_stb(shift_stb)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic strobes(input string tag, input logic es, input logic eh);
    chk({tag, " sample"}, sample_stb, es);
    chk({tag, " shift"}, shift_stb, eh);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic tick_chk(input string tag, input logic el, input logic es, input logic eh);
    @(negedge clk) baud_tick = 1;
    @(negedge clk) baud_tick = 0;
    chk({tag, " level"}, sclk_out, el);
    strobes(tag, es, eh);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cfg_master = 0; cfg_two_stage = 0; cfg_fall_edge = 0;
    cfg_gate_idle = 0; cfg_no_frame = 0; baud_tick = 0; frame_busy = 0; sclk_in = 1;
    idle(3);
    chk("R1 reset sclk_out", sclk_out, 1'b1);
    strobes("R1 reset", 1'b0, 1'b0);
    chk("R2 slave oe", sclk_oe, 1'b0);
    rst_n = 1;
    idle(4);
    chk("R1 after reset sclk_out", sclk_out, 1'b1);
    strobes("R1 after reset", 1'b0, 1'b0);

    // slave one-stage edge table: R7 R8 R5 R9
    for (int v = 0; v < 8; v++) begin
      cfg_fall_edge = VEC[v][4];
      cfg_no_frame  = VEC[v][3];
      sclk_in = ~VEC[v][2];
      idle(4);
      sclk_in = VEC[v][2];
      @(posedge clk);
      @(negedge clk);
      strobes($sformatf("R7/R8 R5 vec%0d", v), VEC[v][1], VEC[v][0]);
      @(negedge clk);
      strobes($sformatf("R9 one pulse vec%0d", v), 1'b0, 1'b0);
    end

    // two-stage latency: R6
    cfg_fall_edge = 0; cfg_no_frame = 0; cfg_two_stage = 1;
    sclk_in = 0; idle(5);
    sclk_in = 1;
    @(posedge clk); @(negedge clk);
    strobes("R6 early", 1'b0, 1'b0);
    @(negedge clk);
    strobes("R6 delayed", 1'b1, 1'b0);
    @(negedge clk);
    strobes("R6 after", 1'b0, 1'b0);
    cfg_two_stage = 0;
    idle(3);

    // slave ignores ticks: R10
    tick_chk("R10 slave tick", 1'b1, 1'b0, 1'b0);

    // master toggling: R2 R3
    cfg_master = 1;
    @(negedge clk);
    chk("R2 master oe", sclk_oe, 1'b1);
    tick_chk("R3 tick1 fall", 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    strobes("R3 single cycle", 1'b0, 1'b0);
    chk("R3 hold", sclk_out, 1'b0);
    tick_chk("R3 tick2 rise", 1'b1, 1'b1, 1'b0);

    // master ignores sclk_in: R10
    sclk_in = 0; @(negedge clk); strobes("R10 pin ignored a", 1'b0, 1'b0);
    @(negedge clk); strobes("R10 pin ignored b", 1'b0, 1'b0);
    sclk_in = 1; @(negedge clk); @(negedge clk);
    strobes("R10 pin ignored c", 1'b0, 1'b0);
    chk("R10 pin ignored level", sclk_out, 1'b1);

    // gating: R4
    cfg_gate_idle = 1; frame_busy = 0;
    tick_chk("R4 parked", 1'b1, 1'b0, 1'b0);
    frame_busy = 1;
    tick_chk("R4 busy runs", 1'b0, 1'b0, 1'b1);
    frame_busy = 0;
    tick_chk("R4 completes period", 1'b1, 1'b1, 1'b0);
    tick_chk("R4 stays parked", 1'b1, 1'b0, 1'b0);
    cfg_gate_idle = 0;
    tick_chk("R4 continuous", 1'b0, 1'b0, 1'b1);
    cfg_no_frame = 1;
    tick_chk("R8 master rise shifts", 1'b1, 1'b0, 1'b1);
    tick_chk("R8 master fall samples", 1'b0, 1'b1, 1'b0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule